// File: doc/BRIEF.md
# Camera Sync Event Interrupt Status

This block watches the control lines of a camera capture path and keeps one sticky flag per event in a single read-only status word. The vertical and horizontal sync lines each raise two separate flags, one for a rising edge and one for a falling edge. The receive FIFO full line raises a flag only on its 0-to-1 transition. A one-cycle trigger pulse, sent when the FIFO reaches its transfer level, raises the data-transfer flag. Every input is synchronous to the system clock.

Software reads the word with a one-cycle read strobe. The read data shows the flags as they were before the read. The same read clears every flag except one whose event arrives in that cycle, so no event is lost. A six-bit enable mask selects which flags drive the single interrupt output. The mask has no effect on the flags themselves.

Top module: `cam_evt_status`

## Requirements
- R1: `rdata_o` holds the six flags at fixed positions: bit 0 vertical sync rising, bit 1 vertical sync falling, bit 2 horizontal sync rising, bit 3 horizontal sync falling, bit 4 FIFO full rising, bit 5 data transfer.
- R2: A rising or falling edge on `vsync_i` or `hsync_i`, taken between two consecutive clock samples, sets the matching flag. The flag is visible after the clock edge at which the new level is sampled.
- R3: The FIFO full flag sets only when `fifo_full_i` goes from 0 to 1. Holding the line high causes no new set after a clear. Each fresh 0-to-1 transition sets the flag again.
- R4: A high `xfer_trig_i` on a clock edge sets bit 5.
- R5: While `rd_i` is high, `rdata_o` shows the flag values from before the clear. At the clock edge that ends the read, every flag with no event in that cycle returns to 0.
- R6: An event that occurs in the same cycle as a read leaves its flag set after that read, and the next read returns it.
- R7: Bits 31 to 6 of `rdata_o` always read 0.
- R8: After reset all flags are 0 and `irq_o` is 0. A sync or FIFO line that is already high when reset ends does not produce an edge on the first cycle after reset.
- R9: `irq_o` is high exactly when some flag is set and its bit in `irq_en_i` is 1. Changing `irq_en_i` does not change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical sync level |
| hsync_i | input | 1 | Horizontal sync level |
| fifo_full_i | input | 1 | Receive FIFO full level |
| xfer_trig_i | input | 1 | One-cycle pulse when the FIFO transfer level is reached |
| rd_i | input | 1 | Read strobe for the status word |
| irq_en_i | input | 6 | Per-flag interrupt enable, same bit positions as the flags |
| rdata_o | output | 32 | Status word |
| irq_o | output | 1 | Combined interrupt |

## Verification
A level change on an input is sampled at one clock edge and shows in `rdata_o` after that same edge. A trigger pulse also appears after the edge that samples it. A read clears the flags at the edge that ends the read, so the post-clear value is due one edge after the strobe. `irq_o` depends only on the flags and the mask, so it follows a mask change within the same cycle. The bench drives inputs on the falling edge. A behavioural model applies the same timing at each rising edge, and the outputs are compared shortly after every falling edge. Directed checks sample at the falling edge that follows the edge under test.

// File: rtl/cam_evt_pkg.sv
package cam_evt_pkg;
  localparam int unsigned EVT_N = 6;

  typedef enum int unsigned {
    EV_VS_RISE   = 0,
    EV_VS_FALL   = 1,
    EV_HS_RISE   = 2,
    EV_HS_FALL   = 3,
    EV_FIFO_FULL = 4,
    EV_XFER      = 5
  } evt_idx_e;
endpackage

// File: rtl/cam_evt_edge.sv
module cam_evt_edge #(
  parameter int unsigned W    = 2,
  parameter bit          BOTH = 1'b1,
  localparam int unsigned OW  = BOTH ? 2 * W : W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  sig_i,
  output logic [OW-1:0] evt_o
);
  logic [W-1:0] prev_q;
  logic         primed_q;
  logic [W-1:0] rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= sig_i;
      primed_q <= 1'b1;
    end
  end

  // no edge until one sample has been taken after reset
  assign rise = primed_q ? (sig_i & ~prev_q) : '0;
  assign fall = primed_q ? (~sig_i & prev_q) : '0;

  generate
    if (BOTH) begin : g_both
      for (genvar i = 0; i < int'(W); i++) begin : g_pair
        assign evt_o[2*i]   = rise[i];
        assign evt_o[2*i+1] = fall[i];
      end
    end else begin : g_rise
      assign evt_o = rise;
    end
  endgenerate

  AST_NO_REPEAT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o != '0) |=> ((evt_o & $past(evt_o)) == '0)); // R3
  AST_NO_EDGE_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (evt_o == '0)); // R8
endmodule

// File: rtl/cam_evt_flags.sv
module cam_evt_flags #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         rd_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d;

  // an event in the read cycle wins over the clear
  assign flag_d = evt_i | (rd_i ? '0 : flag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_SET_ON_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R6
  AST_CLR_ON_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (flag_q == $past(evt_i))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && evt_i == '0) |=> $stable(flag_q)); // R5
endmodule

// File: rtl/cam_evt_status.sv
module cam_evt_status
  import cam_evt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PAD_W = DATA_W - EVT_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic              hsync_i,
  input  logic              fifo_full_i,
  input  logic              xfer_trig_i,
  input  logic              rd_i,
  input  logic [EVT_N-1:0]  irq_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [3:0]       sync_evt;
  logic [0:0]       fifo_evt;
  logic [EVT_N-1:0] evt, flags;

  cam_evt_edge #(.W(2), .BOTH(1'b1)) u_sync_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({hsync_i, vsync_i}),
    .evt_o  (sync_evt)
  );

  cam_evt_edge #(.W(1), .BOTH(1'b0)) u_fifo_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (fifo_full_i),
    .evt_o  (fifo_evt)
  );

  assign evt[EV_HS_FALL:EV_VS_RISE] = sync_evt;
  assign evt[EV_FIFO_FULL]          = fifo_evt[0];
  assign evt[EV_XFER]               = xfer_trig_i;

  cam_evt_flags #(.N(EVT_N)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .rd_i   (rd_i),
    .flag_o (flags)
  );

  assign rdata_o = {{PAD_W{1'b0}}, flags};
  assign irq_o   = |(flags & irq_en_i);

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[EVT_N-1:0] == '0) |-> !irq_o); // R9
  AST_FIFO_ONLY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_full_i && !rd_i) |=> ($past(rdata_o[EV_FIFO_FULL]) == rdata_o[EV_FIFO_FULL])); // R3
endmodule

// File: tb/cam_evt_status_tb.sv
module cam_evt_status_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vsync = 1'b0, hsync = 1'b0, fifo_full = 1'b0, trig = 1'b0, rd = 1'b0;
  logic [5:0]  en = 6'h0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0, wd = 0;
  bit done = 1'b0;

  // reference state
  bit [5:0] m_flags = '0;
  bit       m_vs = 0, m_hs = 0, m_ff = 0, m_primed = 0;

  always #4 clk = ~clk;

  cam_evt_status u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .vsync_i(vsync), .hsync_i(hsync),
    .fifo_full_i(fifo_full), .xfer_trig_i(trig), .rd_i(rd),
    .irq_en_i(en), .rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_flags = '0; m_vs = 0; m_hs = 0; m_ff = 0; m_primed = 0;
    end else begin
      bit [5:0] ev;
      ev = '0;
      if (m_primed) begin
        ev[0] = vsync && !m_vs;  ev[1] = !vsync && m_vs;
        ev[2] = hsync && !m_hs;  ev[3] = !hsync && m_hs;
        ev[4] = fifo_full && !m_ff;
      end
      ev[5] = trig;
      m_flags = ev | (rd ? 6'h0 : m_flags);
      m_vs = vsync; m_hs = hsync; m_ff = fifo_full; m_primed = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model comparison every cycle: R1 layout, R7 reserved, R9 irq
  always @(negedge clk) begin
    #1;
    if (rst_ni && !done) begin
      chk("R1 model", rdata, {26'h0, m_flags});
      chk("R9 model irq", {31'h0, irq}, {31'h0, |(m_flags & en)});
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 5000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=5000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  initial begin
    vsync = 1'b1; fifo_full = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 reset flags", rdata, 32'h0);
    chk("R8 reset irq", {31'h0, irq}, 32'h0);
    rst_ni = 1'b1;
    cyc(); cyc();
    chk("R8 no edge from high-at-reset", rdata, 32'h0);
    fifo_full = 1'b0; cyc(); chk("R3 fifo fall ignored", rdata, 32'h0);
    vsync = 1'b0; cyc(); chk("R2 vsync fall", rdata, 32'h2);
    rd = 1'b1; chk("R5 read shows pre-clear", rdata, 32'h2);
    cyc(); rd = 1'b0; chk("R5 cleared", rdata, 32'h0);
    vsync = 1'b1; cyc(); chk("R2 vsync rise", rdata, 32'h1);
    hsync = 1'b1; cyc(); chk("R2 hsync rise", rdata, 32'h5);
    hsync = 1'b0; cyc(); chk("R2 hsync fall", rdata, 32'hD);
    fifo_full = 1'b1; cyc(); chk("R3 fifo rise", rdata, 32'h1D);
    rd = 1'b1; cyc(); rd = 1'b0; chk("R3 cleared", rdata, 32'h0);
    cyc(); cyc(); chk("R3 held high no retrigger", rdata, 32'h0);
    fifo_full = 1'b0; cyc(); fifo_full = 1'b1; cyc();
    chk("R3 second rise", rdata, 32'h10);
    rd = 1'b1; cyc(); rd = 1'b0;
    trig = 1'b1; cyc(); trig = 1'b0; chk("R4 trigger", rdata, 32'h20);
    cyc(); chk("R4 trigger sticky", rdata, 32'h20);
    rd = 1'b1; trig = 1'b1; chk("R6 read data before clear", rdata, 32'h20);
    cyc(); rd = 1'b0; trig = 1'b0; chk("R6 coincident trigger kept", rdata, 32'h20);
    rd = 1'b1; hsync = 1'b1; cyc(); rd = 1'b0;
    chk("R6 coincident hsync rise kept", rdata, 32'h4);
    en = 6'h00; #1; chk("R9 masked irq", {31'h0, irq}, 32'h0);
    en = 6'h04; #1; chk("R9 enabled irq", {31'h0, irq}, 32'h1);
    en = 6'h3B; #1; chk("R9 other bits irq", {31'h0, irq}, 32'h0);
    cyc(); chk("R9 mask leaves flags", rdata, 32'h4);
    chk("R7 reserved zero", {6'h0, rdata[31:6]}, 32'h0);
    en = 6'h3F; vsync = 1'b0; cyc();
    chk("R1 bit layout", rdata, 32'h6);
    chk("R9 irq any", {31'h0, irq}, 32'h1);
    rd = 1'b1; cyc(); rd = 1'b0;
    chk("R5 final clear", rdata, 32'h0);
    chk("R9 irq low when clear", {31'h0, irq}, 32'h0);
    cyc();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule